// File: doc/BRIEF.md
# Capacitor Precharge Sequencer

This block brings a stacked capacitor energy buffer up to its starting charge before the normal-mode switching controller takes over. After a start request it steers a single current-source precharge path to one capacitor at a time. It visits every supporting capacitor first, then each backbone capacitor. For each capacitor it presents a reference code to a DAC and a channel number to the sense multiplexer. It then waits until a synchronized comparator flag shows that the sensed voltage has reached the reference. Once the last capacitor is charged it opens both precharge isolation switches and raises a done flag for the normal-mode sequencer.

The state machine has five states. IDLE is entered at reset and waits for start (IDLE->CHARGE). CHARGE routes the path to the current capacitor. It leaves on acceptance, either to GAP (CHARGE->GAP) or, after the final capacitor, to FINISHED (CHARGE->FINISHED). If the step overruns it goes to FAULT (CHARGE->FAULT). GAP is a one-cycle break with only the isolation switches closed (GAP->CHARGE). FINISHED and FAULT are terminal until reset. A step is accepted when its target code is zero, or when the comparator reports reached after a settle window. A per-step counter bounds how long a step may wait.

Top module: `cap_precharge_seq`

## Requirements
- R1: While reset is asserted and after it is released, every switch output is off, dac_code and sense_sel are 0, and done and fault are low.
- R2: Capacitors are charged in this order: supporting 0 to NUM_SUPPORT-1, then backbone 0 to NUM_BACKBONE-1. sense_sel shows the step index: supporting k is k, and backbone j is NUM_SUPPORT+j.
- R3: While supporting capacitor k charges, iso_pos, iso_neg, bridge_fwd, sup_return and sup_sel[k] are on, and every other switch is off.
- R4: While backbone capacitor j charges, iso_pos, iso_neg, bridge_rev and bb_sel[j] are on, and every other switch is off. bridge_fwd and bridge_rev are never on together.
- R5: dac_code is (NUM_SUPPORT-1-k)*NOM_CODE/10 for supporting capacitor k and BB_TENTHS*NOM_CODE/10 for any backbone capacitor. With the defaults the codes in charge order are 100, 80, 60, 40, 20, 0, 80, 80.
- R6: A step with a nonzero target advances only on cmp_reached sampled high once the step has spent at least SETTLE_CYCLES cycles in CHARGE. cmp_reached during the first SETTLE_CYCLES cycles of a step is ignored.
- R7: A step whose target code is 0 leaves CHARGE after exactly one cycle, with cmp_reached low.
- R8: Between two steps there is exactly one cycle in which no capacitor select, bridge or return switch is on, while iso_pos and iso_neg stay on. A capacitor select never changes directly to another select.
- R9: After the last backbone step is accepted, all switches open, done goes high and stays high, and start and cmp_reached then have no effect.
- R10: If a step is not accepted within TIMEOUT_CYCLES cycles of CHARGE, fault rises in the next cycle and every switch opens. fault holds until reset, and start has no effect while it is high.
- R11: In IDLE, cmp_reached has no effect, and a start pulse begins CHARGE of the first capacitor on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the precharge sequence (sampled in IDLE only) |
| cmp_reached | input | 1 | Synchronized comparator flag: sensed voltage at or above reference |
| sup_sel | output | NUM_SUPPORT | Per-capacitor select switches of the supporting capacitors |
| bb_sel | output | NUM_BACKBONE | Per-capacitor select switches of the backbone capacitors |
| iso_pos | output | 1 | Precharge isolation switch, positive rail |
| iso_neg | output | 1 | Precharge isolation switch, return rail |
| bridge_fwd | output | 1 | Bridge leg used while supporting capacitors charge |
| bridge_rev | output | 1 | Bridge leg used while backbone capacitors charge |
| sup_return | output | 1 | Return switch closing the supporting-capacitor charge loop |
| dac_code | output | DAC_W | Reference code for the comparator DAC |
| sense_sel | output | clog2(NUM_SUPPORT+NUM_BACKBONE) | Sense channel select (step index) |
| done | output | 1 | Precharge complete, path isolated |
| fault | output | 1 | A step timed out; all switches open |

## Verification
The timeout fault is the hardest condition to reach from the ports, because a well-behaved comparator always trips. The bench builds the block with a short timeout and holds cmp_reached low from the first step. It then counts cycles so that it can confirm fault is still low one cycle before the limit and high exactly at it. The settle blanking is also hard to observe. To expose it, the bench raises cmp_reached in the first cycle of every nonzero step and checks that the switch set stays unchanged for SETTLE_CYCLES cycles. The zero-target step is run with the comparator held low.

// File: rtl/pchg_pkg.sv
`timescale 1ns/1ps
package pchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CHARGE   = 3'd1,
        ST_GAP      = 3'd2,
        ST_FINISHED = 3'd3,
        ST_FAULT    = 3'd4
    } pchg_state_e;

    // Scale a target expressed in tenths of nominal into a DAC code.
    function automatic int unsigned tenths_to_code(input int unsigned tenths,
                                                   input int unsigned nom_code);
        return (tenths * nom_code) / 10;
    endfunction

endpackage

// File: rtl/pchg_step_map.sv
`timescale 1ns/1ps
module pchg_step_map
    import pchg_pkg::*;
#(
    parameter int NUM_SUPPORT  = 6,
    parameter int NUM_BACKBONE = 2,
    parameter int DAC_W        = 8,
    parameter int NOM_CODE     = 200,
    parameter int BB_TENTHS    = 4,
    localparam int NSTEP       = NUM_SUPPORT + NUM_BACKBONE,
    localparam int STEP_W      = $clog2(NSTEP)
) (
    input  logic [STEP_W-1:0]       step,
    output logic [NUM_SUPPORT-1:0]  sup_oh,
    output logic [NUM_BACKBONE-1:0] bb_oh,
    output logic                    is_backbone,
    output logic [DAC_W-1:0]        code,
    output logic                    zero_target
);

    localparam int unsigned BB_CODE = tenths_to_code(BB_TENTHS, NOM_CODE);

    genvar k;
    generate
        for (k = 0; k < NUM_SUPPORT; k++) begin : g_sup
            assign sup_oh[k] = (step == STEP_W'(k));
        end
        for (k = 0; k < NUM_BACKBONE; k++) begin : g_bb
            assign bb_oh[k] = (step == STEP_W'(NUM_SUPPORT + k));
        end
    endgenerate

    assign is_backbone = (int'(step) >= NUM_SUPPORT);

    always_comb begin
        int unsigned c;
        if (is_backbone) begin
            c = BB_CODE;
        end else begin
            c = tenths_to_code(NUM_SUPPORT - 1 - int'(step), NOM_CODE);
        end
        code        = DAC_W'(c);
        zero_target = (c == 0);
    end

endmodule

// File: rtl/pchg_step_timer.sv
`timescale 1ns/1ps
module pchg_step_timer #(
    parameter int SETTLE_CYCLES  = 2,
    parameter int TIMEOUT_CYCLES = 1000000,
    localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic settled,
    output logic expired
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = (cnt >= CNT_W'(SETTLE_CYCLES));
    assign expired = run && (cnt == LAST);

    // R10: count never passes the last step cycle
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/cap_precharge_seq.sv
`timescale 1ns/1ps
module cap_precharge_seq
    import pchg_pkg::*;
#(
    parameter int NUM_SUPPORT    = 6,
    parameter int NUM_BACKBONE   = 2,
    parameter int DAC_W          = 8,
    parameter int NOM_CODE       = 200,
    parameter int BB_TENTHS      = 4,
    parameter int SETTLE_CYCLES  = 2,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic                                       cmp_reached,
    output logic [NUM_SUPPORT-1:0]                     sup_sel,
    output logic [NUM_BACKBONE-1:0]                    bb_sel,
    output logic                                       iso_pos,
    output logic                                       iso_neg,
    output logic                                       bridge_fwd,
    output logic                                       bridge_rev,
    output logic                                       sup_return,
    output logic [DAC_W-1:0]                           dac_code,
    output logic [$clog2(NUM_SUPPORT+NUM_BACKBONE)-1:0] sense_sel,
    output logic                                       done,
    output logic                                       fault
);

    localparam int NSTEP  = NUM_SUPPORT + NUM_BACKBONE;
    localparam int STEP_W = $clog2(NSTEP);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

    pchg_state_e       state, state_n;
    logic [STEP_W-1:0] step, step_n;

    logic [NUM_SUPPORT-1:0]  map_sup;
    logic [NUM_BACKBONE-1:0] map_bb;
    logic                    map_is_bb;
    logic [DAC_W-1:0]        map_code;
    logic                    map_zero;
    logic                    tmr_settled;
    logic                    tmr_expired;
    logic                    accept;

    pchg_step_map #(
        .NUM_SUPPORT (NUM_SUPPORT),
        .NUM_BACKBONE(NUM_BACKBONE),
        .DAC_W       (DAC_W),
        .NOM_CODE    (NOM_CODE),
        .BB_TENTHS   (BB_TENTHS)
    ) u_map (
        .step       (step),
        .sup_oh     (map_sup),
        .bb_oh      (map_bb),
        .is_backbone(map_is_bb),
        .code       (map_code),
        .zero_target(map_zero)
    );

    pchg_step_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_CHARGE),
        .settled(tmr_settled),
        .expired(tmr_expired)
    );

    assign accept = map_zero || (cmp_reached && tmr_settled);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_n;
            step  <= step_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        step_n  = step;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_CHARGE;
                    step_n  = '0;
                end
            end
            ST_CHARGE: begin
                if (accept) begin
                    if (step == LAST_STEP) begin
                        state_n = ST_FINISHED;
                    end else begin
                        state_n = ST_GAP;
                        step_n  = step + 1'b1;
                    end
                end else if (tmr_expired) begin
                    state_n = ST_FAULT;
                end
            end
            ST_GAP:      state_n = ST_CHARGE;
            ST_FINISHED: state_n = ST_FINISHED;
            ST_FAULT:    state_n = ST_FAULT;
            default:     state_n = ST_FAULT;
        endcase
    end

    // Output logic
    always_comb begin
        sup_sel    = '0;
        bb_sel     = '0;
        iso_pos    = 1'b0;
        iso_neg    = 1'b0;
        bridge_fwd = 1'b0;
        bridge_rev = 1'b0;
        sup_return = 1'b0;
        dac_code   = '0;
        sense_sel  = '0;
        done       = 1'b0;
        fault      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CHARGE: begin
                iso_pos   = 1'b1;
                iso_neg   = 1'b1;
                dac_code  = map_code;
                sense_sel = step;
                if (map_is_bb) begin
                    bb_sel     = map_bb;
                    bridge_rev = 1'b1;
                end else begin
                    sup_sel    = map_sup;
                    bridge_fwd = 1'b1;
                    sup_return = 1'b1;
                end
            end
            ST_GAP: begin
                iso_pos   = 1'b1;
                iso_neg   = 1'b1;
                dac_code  = map_code;
                sense_sel = step;
            end
            ST_FINISHED: done  = 1'b1;
            ST_FAULT:    fault = 1'b1;
            default:     fault = 1'b1;
        endcase
    end

    // R3
    one_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sup_sel, bb_sel}));

    // R4
    bridge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bridge_fwd && bridge_rev));

    // R8
    break_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({sup_sel, bb_sel} != '0) |=>
            (({sup_sel, bb_sel} == $past({sup_sel, bb_sel})) || ({sup_sel, bb_sel} == '0)));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9
    done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(iso_pos || iso_neg || bridge_fwd || bridge_rev || sup_return || (|sup_sel) || (|bb_sel)));

    // R10
    fault_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !(iso_pos || iso_neg || bridge_fwd || bridge_rev || sup_return || (|sup_sel) || (|bb_sel)));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && !done));

endmodule

// File: tb/cap_precharge_seq_test.sv
`timescale 1ns/1ps
module cap_precharge_seq_test;

    localparam int NS      = 6;
    localparam int NB      = 2;
    localparam int SETTLE  = 2;
    localparam int TIMEOUT = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmp_reached = 1'b0;
    logic [NS-1:0] sup_sel;
    logic [NB-1:0] bb_sel;
    logic          iso_pos, iso_neg, bridge_fwd, bridge_rev, sup_return;
    logic [7:0]    dac_code;
    logic [2:0]    sense_sel;
    logic          done, fault;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cap_precharge_seq #(
        .SETTLE_CYCLES (SETTLE),
        .TIMEOUT_CYCLES(TIMEOUT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_reached(cmp_reached),
        .sup_sel(sup_sel), .bb_sel(bb_sel), .iso_pos(iso_pos), .iso_neg(iso_neg),
        .bridge_fwd(bridge_fwd), .bridge_rev(bridge_rev), .sup_return(sup_return),
        .dac_code(dac_code), .sense_sel(sense_sel), .done(done), .fault(fault)
    );

    // {sup_sel, bb_sel, bridge_fwd, bridge_rev, sup_return, dac_code}
    localparam logic [18:0] STEP_TBL [8] = '{
        {6'b000001, 2'b00, 3'b101, 8'd100},
        {6'b000010, 2'b00, 3'b101, 8'd80},
        {6'b000100, 2'b00, 3'b101, 8'd60},
        {6'b001000, 2'b00, 3'b101, 8'd40},
        {6'b010000, 2'b00, 3'b101, 8'd20},
        {6'b100000, 2'b00, 3'b101, 8'd0},
        {6'b000000, 2'b01, 3'b010, 8'd80},
        {6'b000000, 2'b10, 3'b010, 8'd80}
    };

    function automatic logic [18:0] obs();
        return {sup_sel, bb_sel, bridge_fwd, bridge_rev, sup_return, dac_code};
    endfunction

    function automatic logic [21:0] all_out();
        return {sup_sel, bb_sel, iso_pos, iso_neg, bridge_fwd, bridge_rev,
                sup_return, dac_code, sense_sel};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        check("R1 outputs in reset", 32'(all_out()), 32'd0);
        check("R1 flags in reset", {30'd0, done, fault}, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1 outputs after release", 32'(all_out()), 32'd0);

        // R11 comparator ignored in IDLE
        cmp_reached = 1'b1;
        repeat (3) tick();
        check("R11 idle ignores cmp", 32'(all_out()), 32'd0);
        cmp_reached = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NS + NB; i++) begin
            logic zero_step;
            zero_step = (STEP_TBL[i][7:0] == 8'd0);
            check($sformatf("R3/R4/R5 step %0d switches+code", i), 32'(obs()), 32'(STEP_TBL[i]));
            check($sformatf("R2 step %0d sense", i), 32'(sense_sel), 32'(i));
            check($sformatf("R3/R4 step %0d isolation", i), {30'd0, iso_pos, iso_neg}, 32'd3);
            if (zero_step) begin
                cmp_reached = 1'b0;   // R7
            end else begin
                cmp_reached = 1'b1;
                for (int s = 0; s < SETTLE; s++) begin
                    tick();
                    check($sformatf("R6 step %0d held in settle", i), 32'(obs()), 32'(STEP_TBL[i]));
                end
            end
            tick();
            if (i < NS + NB - 1) begin
                check($sformatf("R8 gap after step %0d", i),
                      {8'd0, sup_sel, bb_sel, iso_pos, iso_neg, bridge_fwd, bridge_rev, sup_return},
                      {8'd0, 6'd0, 2'd0, 5'b11000});
                check($sformatf("R2 gap sense after step %0d", i), 32'(sense_sel), 32'(i + 1));
                if (zero_step) check("R7 zero target leaves in one cycle", 32'(done), 32'd0);
                cmp_reached = 1'b0;
                tick();
            end else begin
                check("R9 done raised", {30'd0, done, fault}, 32'd2);
                check("R9 switches open", 32'(all_out()), 32'd0);
            end
        end

        // R9 start and cmp ignored after completion
        start = 1'b1;
        cmp_reached = 1'b1;
        repeat (3) tick();
        start = 1'b0;
        cmp_reached = 1'b0;
        check("R9 done held", {30'd0, done, fault}, 32'd2);
        check("R9 start ignored", 32'(all_out()), 32'd0);

        // R10 timeout with comparator never tripping
        rst_n = 1'b0;
        tick();
        check("R1 reset clears done", {30'd0, done, fault}, 32'd0);
        rst_n = 1'b1;
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int k = 1; k < TIMEOUT; k++) tick();
        check("R10 no fault before limit", {30'd0, done, fault}, 32'd0);
        check("R10 still charging step 0", 32'(obs()), 32'(STEP_TBL[0]));
        tick();
        check("R10 fault at limit", {30'd0, done, fault}, 32'd1);
        check("R10 switches open on fault", 32'(all_out()), 32'd0);
        start = 1'b1;
        cmp_reached = 1'b1;
        repeat (3) tick();
        start = 1'b0;
        cmp_reached = 1'b0;
        check("R10 fault sticky", {30'd0, done, fault}, 32'd1);
        check("R10 start ignored in fault", 32'(all_out()), 32'd0);

        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset clears fault", {30'd0, done, fault}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule